// File: doc/BRIEF.md
# 64-bit Compare Timer with Periodic Re-arm

The block keeps a free-running 64-bit up-counter and one 64-bit compare value. Software reaches both through a narrow 32-bit register port that uses single-cycle read and write strobes. When compare is enabled and the count is at or past the compare value, a sticky event flag is set. The interrupt line is that flag gated by an interrupt-enable bit, and it stays high as a level until software clears the flag. An optional 32-bit step value can be added to the compare value on every event, which gives periodic events with no software reload.

Each 64-bit quantity is split into two 32-bit words. To get a coherent count, software reads the upper word, then the lower word, then the upper word again, and retries while the two upper reads differ. The counter carries from its low word into its high word inside the same clock, so this read sequence always converges. Read data is combinational and appears in the same cycle as the read strobe.

Top module: `cmp_timer64`

## Requirements
- R1: After reset every register reads zero and `irqOut` is low.
- R2: While control bit 0 is set, the counter rises by one on every clock. While it is clear, the counter holds. Byte offset 0x00 writes and reads the low word and 0x04 the high word.
- R3: Offsets 0x10/0x14 hold the compare low/high words, 0x18 the step value, 0x08 control and 0x0C status. A read of any other offset returns zero, and a write to it changes nothing.
- R4: Control holds four bits: bit 0 counter enable, bit 1 compare enable, bit 2 interrupt enable, bit 3 periodic re-arm. Upper bits read as zero.
- R5: The event flag (status bit 0) is set one clock after a cycle in which compare is enabled and the unsigned count is greater than or equal to the compare value. This includes a compare value already below the count.
- R6: Writing status with bit 0 set clears the flag. Writing status with bit 0 clear leaves the flag unchanged.
- R7: If a clear and an event fall in the same cycle, the flag stays set.
- R8: With periodic re-arm set, each event adds the step value to the compare value in the clock after it.
- R9: Compare writes made while compare is disabled never set the flag.
- R10: `irqOut` equals the flag ANDed with control bit 2.
- R11: The upper/lower/upper read sequence across a low-word rollover returns the exact 64-bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Read strobe; data valid in the same cycle |
| addr | input | 5 | Byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, zero when not reading |
| irqOut | output | 1 | Level interrupt |

## Verification
Two flag updates can land on the same clock: the event that sets the flag and the software write that clears it. The bench provokes this by leaving compare enabled with the compare value far below the count, so the event condition is true on every clock. It then issues a write-one clear. The flag must still read as set after that edge. Only after compare is disabled may a clear leave the flag at zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_CMP_LO = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_CMP_HI = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_STEP   = 5'h18;

  // control bit positions
  localparam int unsigned CB_CNT  = 0;
  localparam int unsigned CB_CMP  = 1;
  localparam int unsigned CB_IRQ  = 2;
  localparam int unsigned CB_AUTO = 3;
  localparam int unsigned CTRL_W  = 4;

  typedef struct packed {
    logic cntLoWr;
    logic cntHiWr;
    logic cmpLoWr;
    logic cmpHiWr;
    logic stepWr;
    logic flagClr;
    logic cntEn;
    logic cmpEn;
    logic autoEn;
  } dpStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wrData,
  input  logic [2*W-1:0] cntVal,
  input  logic [2*W-1:0] cmpVal,
  input  logic [W-1:0]  stepVal,
  input  logic          flag,
  output dpStrobe_t     strb,
  output logic [W-1:0]  rdData,
  output logic          irqOut
);
  logic [CTRL_W-1:0] ctrlReg;
  logic wrCtrl;

  assign wrCtrl = wrEn && (addr == OFF_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrlReg <= '0;
    else if (wrCtrl) ctrlReg <= wrData[CTRL_W-1:0];
  end

  always_comb begin
    strb         = '0;
    strb.cntLoWr = wrEn && (addr == OFF_CNT_LO);
    strb.cntHiWr = wrEn && (addr == OFF_CNT_HI);
    strb.cmpLoWr = wrEn && (addr == OFF_CMP_LO);
    strb.cmpHiWr = wrEn && (addr == OFF_CMP_HI);
    strb.stepWr  = wrEn && (addr == OFF_STEP);
    strb.flagClr = wrEn && (addr == OFF_STAT) && wrData[0];
    strb.cntEn   = ctrlReg[CB_CNT];
    strb.cmpEn   = ctrlReg[CB_CMP];
    strb.autoEn  = ctrlReg[CB_AUTO];
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        OFF_CNT_LO: rdData = cntVal[W-1:0];
        OFF_CNT_HI: rdData = cntVal[2*W-1:W];
        OFF_CTRL:   rdData = {{(W-CTRL_W){1'b0}}, ctrlReg};
        OFF_STAT:   rdData = {{(W-1){1'b0}}, flag};
        OFF_CMP_LO: rdData = cmpVal[W-1:0];
        OFF_CMP_HI: rdData = cmpVal[2*W-1:W];
        OFF_STEP:   rdData = stepVal;
        default:    rdData = '0;
      endcase
    end
  end

  assign irqOut = flag && ctrlReg[CB_IRQ];

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> flag); // R10
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrCtrl |=> $stable(ctrlReg)); // R4
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  dpStrobe_t      strb,
  input  logic [W-1:0]   wrData,
  output logic [2*W-1:0] cntVal,
  output logic [2*W-1:0] cmpVal,
  output logic [W-1:0]   stepVal,
  output logic           flag
);
  localparam int unsigned CW = 2 * W;

  logic hit;
  logic cntWr, cmpWr;

  assign cntWr = strb.cntLoWr || strb.cntHiWr;
  assign cmpWr = strb.cmpLoWr || strb.cmpHiWr;
  assign hit   = strb.cmpEn && (cntVal >= cmpVal);

  // counter: word writes take priority over counting
  always_ff @(posedge clk) begin
    if (!rst_n)            cntVal <= '0;
    else if (strb.cntLoWr) cntVal[W-1:0]  <= wrData;
    else if (strb.cntHiWr) cntVal[CW-1:W] <= wrData;
    else if (strb.cntEn)   cntVal <= cntVal + CW'(1);
  end

  // compare value: software write wins over periodic re-arm
  always_ff @(posedge clk) begin
    if (!rst_n)                     cmpVal <= '0;
    else if (strb.cmpLoWr)          cmpVal[W-1:0]  <= wrData;
    else if (strb.cmpHiWr)          cmpVal[CW-1:W] <= wrData;
    else if (hit && strb.autoEn)    cmpVal <= cmpVal + {{W{1'b0}}, stepVal};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          stepVal <= '0;
    else if (strb.stepWr) stepVal <= wrData;
  end

  // event flag: set beats clear
  always_ff @(posedge clk) begin
    if (!rst_n)            flag <= 1'b0;
    else if (hit)          flag <= 1'b1;
    else if (strb.flagClr) flag <= 1'b0;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.cntEn && !cntWr) |=> cntVal == $past(cntVal) + CW'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.cntEn && !cntWr) |=> $stable(cntVal)); // R2
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag); // R7
  AST_REARM_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && strb.autoEn && !cmpWr) |=> cmpVal == $past(cmpVal) + {{W{1'b0}}, $past(stepVal)}); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(strb.cmpEn)); // R9
endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
  import tmr_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdData,
  output logic          irqOut
);
  dpStrobe_t       strb;
  logic [2*W-1:0]  cntVal, cmpVal;
  logic [W-1:0]    stepVal;
  logic            flag;

  tmr_ctrl #(.W(W), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .cntVal(cntVal), .cmpVal(cmpVal), .stepVal(stepVal),
    .flag(flag), .strb(strb), .rdData(rdData), .irqOut(irqOut)
  );

  tmr_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData),
    .cntVal(cntVal), .cmpVal(cmpVal), .stepVal(stepVal), .flag(flag)
  );
endmodule

// File: tb/cmp_timer64_bench.sv
module cmp_timer64_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;
  int nChk = 0, nBad = 0;
  bit finished = 0;

  cmp_timer64 u_cmp_timer64 (.clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut));

  always #5 clk = ~clk;

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; rdEn = 1'b1; #1; d = rdData; rdEn = 1'b0;
  endtask

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic rdChk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v); chk(req, v, exp);
  endtask

  task automatic testReset();
    rdChk("R1 cntLo", 5'h00, 0); rdChk("R1 cntHi", 5'h04, 0);
    rdChk("R1 ctrl", 5'h08, 0);  rdChk("R1 stat", 5'h0C, 0);
    rdChk("R1 cmpLo", 5'h10, 0); rdChk("R1 step", 5'h18, 0);
    chk("R1 irq", irqOut, 0);
  endtask

  task automatic testOneShot();
    wr(5'h08, 0); wr(5'h00, 100); wr(5'h04, 0);
    wr(5'h10, 105); wr(5'h14, 0);
    wr(5'h08, 32'h6);
    rdChk("R9 no flag while count below", 5'h0C, 0);
    wr(5'h08, 32'h7);            // enable counter at edge E0
    repeat (5) tick();           // after E5: count 105, flag not yet
    chk("R5 flag before match edge", irqOut, 0);
    tick();
    chk("R5 one-shot irq", irqOut, 1);
    rdChk("R6 status set", 5'h0C, 1);
    wr(5'h08, 0);
  endtask

  task automatic testPeriodic();
    wr(5'h0C, 1); wr(5'h00, 0); wr(5'h04, 0);
    wr(5'h10, 10); wr(5'h14, 0); wr(5'h18, 4);
    rdChk("R6 cleared", 5'h0C, 0);
    wr(5'h08, 32'hF);            // E0
    repeat (10) tick();
    rdChk("R8 no event yet", 5'h0C, 0);
    tick();                      // after E11
    rdChk("R8 first event", 5'h0C, 1);
    rdChk("R8 cmp advanced", 5'h10, 14);
    wr(5'h0C, 1);                // clear at E12
    rdChk("R6 clear by write-one", 5'h0C, 0);
    repeat (2) tick();
    chk("R8 quiet before period", irqOut, 0);
    tick();                      // after E15
    chk("R8 second event", irqOut, 1);
    rdChk("R8 cmp advanced again", 5'h10, 18);
    wr(5'h08, 0);
  endtask

  task automatic testBelowAndRace();
    logic [31:0] a, b;
    wr(5'h0C, 1); wr(5'h00, 500); wr(5'h04, 0);
    wr(5'h10, 20); wr(5'h14, 0);
    rdChk("R9 cmp write while disabled", 5'h0C, 0);
    rd(5'h00, a); tick(); rd(5'h00, b);
    chk("R2 counter holds", b, a);
    chk("R2 counter value", a, 500);
    wr(5'h08, 32'h2);            // E0
    rdChk("R5 not yet", 5'h0C, 0);
    tick();
    rdChk("R5 below-count match", 5'h0C, 1);
    chk("R10 masked irq", irqOut, 0);
    wr(5'h0C, 1);                // clear coincides with live event
    rdChk("R7 set wins over clear", 5'h0C, 1);
    wr(5'h08, 32'h6);
    chk("R10 irq with enable", irqOut, 1);
    wr(5'h08, 0);
    chk("R10 irq off", irqOut, 0);
    wr(5'h0C, 0);
    rdChk("R6 write zero ignored", 5'h0C, 1);
    wr(5'h0C, 1);
    rdChk("R6 clear after disable", 5'h0C, 0);
  endtask

  task automatic testRollover();
    logic [31:0] h1, lo, h2;
    int retries = 0;
    wr(5'h00, 32'hFFFF_FFFE); wr(5'h04, 5);
    wr(5'h08, 1);                // E0
    rd(5'h04, h1);
    forever begin
      tick(); rd(5'h00, lo);
      tick(); rd(5'h04, h2);
      if (h2 == h1) break;
      h1 = h2; retries++;
    end
    chk("R11 coherent value", {h2, lo}, 64'h6_0000_0001);
    chk("R11 one retry", retries, 1);
    wr(5'h08, 0);
  endtask

  task automatic testMap();
    wr(5'h1C, 32'hFFFF_FFFF);
    rdChk("R3 unmapped read", 5'h1C, 0);
    rdChk("R3 step intact", 5'h18, 4);
    rdChk("R3 ctrl intact", 5'h08, 0);
    wr(5'h14, 32'hABCD);
    rdChk("R3 cmp high", 5'h14, 32'hABCD);
    wr(5'h08, 32'hFFFF_FFF0);
    rdChk("R4 upper ctrl bits zero", 5'h08, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    testReset();
    testOneShot();
    testPeriodic();
    testBelowAndRace();
    testRollover();
    testMap();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule